// File: doc/BRIEF.md
# Short-Header Block Encoder (52-symbol, 8-stage shift register)

This block turns one 9-bit header word into a 52-symbol codeword and sends the symbols out one per handshake. The low eight bits of the word become the initial contents of an 8-stage feedback shift register built on the generator polynomial x^8+x^7+x^6+x^5+x^4+x+1 (octal 763). The register is clocked 51 times, and each bit that leaves it is XORed with bit 8 of the word. Bit 8 itself is sent on its own before those 51 symbols, so the codeword is bit 8 followed by the 51 modified register outputs.

The word enters through a valid/ready port. The symbols leave through a valid/ready serial port that carries a last-symbol flag. While a codeword is being sent the input is closed. Backpressure on the output freezes the register and the symbol index.

Control is a three-state machine. IDLE holds `in_ready` high and moves to HEAD when a word is accepted. HEAD presents bit 8 and moves to BODY when that symbol is taken. BODY presents the register outputs and returns to IDLE when the symbol flagged last is taken. In every other case each state stays where it is.

Top module: `bch_short_encoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` is 1 only while no codeword is being sent. A word is taken on a cycle with `in_valid` and `in_ready` both high. While a codeword is in progress, `in_valid` and `in_word` have no effect on the symbols sent.
- R3: Symbol 0 of each codeword is `in_word[8]`.
- R4: Symbol k, for k = 1 to 51, is `in_word[8]` XOR s[k-1]. The sequence s is defined by s[i] = `in_word[7-i]` for i = 0 to 7 and by s[n+8] = s[n] ^ s[n+1] ^ s[n+4] ^ s[n+5] ^ s[n+6] ^ s[n+7].
- R5: Each codeword has exactly 52 symbols (indices 0 to 51). `out_last` is 1 on symbol 51 and 0 on all others.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_sym` and `out_last` hold their values and the codeword does not advance.
- R7: In the cycle after the last symbol is accepted, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Header word offered |
| in_ready | output | 1 | Encoder can take a word |
| in_word | input | 9 | Header word; bit 8 is the prefix bit, bits 7..0 seed the register |
| out_valid | output | 1 | A symbol is presented |
| out_ready | input | 1 | Sink takes the symbol |
| out_sym | output | 1 | Current codeword symbol |
| out_last | output | 1 | Marks symbol 51 |

## Verification
All 512 input words are encoded, so every register seed is tried with bit 8 both clear and set. The seeds alone tell apart wrong tap positions, a wrong shift direction and a missing or off-by-one shift, and flipping bit 8 shows whether the XOR and the prefix are applied. Each word is also run with stalls placed at positions that depend on the word, which separates correct holding under backpressure from a register that slips. The input is driven with a conflicting word throughout emission, which exposes any leak from the input port into a codeword in progress.

// File: rtl/bch_enc_pkg.sv
package bch_enc_pkg;

    localparam int unsigned HDR_W      = 9;
    localparam int unsigned SEED_W     = HDR_W - 1;
    localparam int unsigned CODE_LEN   = 52;
    localparam int unsigned BODY_LEN   = CODE_LEN - 1;
    // stages XORed into the feedback: 7,6,3,2,1,0 (generator octal 763)
    localparam logic [SEED_W-1:0] FB_MASK = 8'b1100_1111;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_BODY = 2'd2
    } enc_state_t;

endpackage

// File: rtl/bch_shift_reg.sv
module bch_shift_reg #(
    parameter int unsigned WIDTH = 8,
    parameter logic [WIDTH-1:0] MASK = 8'b1100_1111
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] seed,
    input  logic             shift,
    output logic             tap_out
);

    logic [WIDTH-1:0] stages;
    logic             fb_bit;

    always_comb begin
        fb_bit = ^(stages & MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stages <= '0;
        end else if (load) begin
            stages <= seed;
        end else if (shift) begin
            stages <= {stages[WIDTH-2:0], fb_bit};
        end
    end

    assign tap_out = stages[WIDTH-1];

    // R6: with no load and no shift the register keeps its contents
    p_reg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(stages));

    // R4: a load places the seed in the register
    p_reg_seed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (stages == $past(seed)));

endmodule

// File: rtl/bch_sym_index.sv
module bch_sym_index #(
    parameter int unsigned LENGTH = 52,
    localparam int unsigned IDX_W = $clog2(LENGTH),
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LENGTH - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] index,
    output logic             at_last
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index <= '0;
        end else if (clear) begin
            index <= '0;
        end else if (step) begin
            index <= index + 1'b1;
        end
    end

    always_comb begin
        at_last = (index == LAST_IDX);
    end

    // R5: the index never passes the final symbol position
    p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        index <= LAST_IDX);

    // R6: without a step or a clear the index is frozen
    p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !step) |=> $stable(index));

endmodule

// File: rtl/bch_short_encoder.sv
module bch_short_encoder
    import bch_enc_pkg::*;
#(
    parameter int unsigned WORD_W = HDR_W,
    parameter int unsigned SYM_COUNT = CODE_LEN,
    localparam int unsigned REG_W = WORD_W - 1,
    localparam int unsigned IDX_W = $clog2(SYM_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_sym,
    output logic              out_last
);

    enc_state_t       state_q;
    enc_state_t       state_d;
    logic             prefix_q;
    logic             take_word;
    logic             take_sym;
    logic             reg_shift;
    logic             reg_tap;
    logic [IDX_W-1:0] sym_idx;
    logic             idx_last;
    logic             idx_clear;

    always_comb begin
        take_word = in_valid && in_ready;
        take_sym  = out_valid && out_ready;
        reg_shift = take_sym && (state_q == ST_BODY);
        idx_clear = take_word || (take_sym && idx_last);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take_word)             state_d = ST_HEAD;
            ST_HEAD: if (take_sym)              state_d = ST_BODY;
            ST_BODY: if (take_sym && idx_last)  state_d = ST_IDLE;
            default:                            state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prefix_q <= 1'b0;
        end else if (take_word) begin
            prefix_q <= in_word[WORD_W-1];
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_sym   = 1'b0;
        out_last  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
            end
            ST_HEAD: begin
                out_valid = 1'b1;
                out_sym   = prefix_q;
            end
            ST_BODY: begin
                out_valid = 1'b1;
                out_sym   = prefix_q ^ reg_tap;
                out_last  = idx_last;
            end
            default: begin
                in_ready = 1'b0;
            end
        endcase
    end

    bch_shift_reg #(
        .WIDTH (REG_W),
        .MASK  (FB_MASK)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take_word),
        .seed    (in_word[REG_W-1:0]),
        .shift   (reg_shift),
        .tap_out (reg_tap)
    );

    bch_sym_index #(
        .LENGTH (SYM_COUNT)
    ) u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (idx_clear),
        .step    (take_sym),
        .index   (sym_idx),
        .at_last (idx_last)
    );

    // R2: input closed while a codeword is presented
    p_busy_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R3: first symbol after acceptance is the prefix bit, not last
    p_first_sym_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_word |=> (out_valid && !out_last && out_sym == $past(in_word[WORD_W-1])));

    // R6: a stalled symbol is held
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sym) && $stable(out_last)));

    // R7: block reopens right after the final symbol
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_sym && out_last) |=> (in_ready && !out_valid));

    // R5: the last flag only at the final index
    p_last_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (sym_idx == IDX_W'(SYM_COUNT - 1)));

endmodule

// File: tb/bch_short_encoder_bench.sv
module bch_short_encoder_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [8:0] in_word = '0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic       out_sym;
    logic       out_last;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bch_short_encoder u_bch_short_encoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_word   (in_word),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_sym   (out_sym),
        .out_last  (out_last)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // codeword from the recurrence in R3/R4; bit k is symbol k
    function automatic logic [51:0] codeword(input logic [8:0] w);
        logic [58:0] s;
        logic [51:0] cw;
        s = '0;
        for (int i = 0; i < 8; i++) s[i] = w[7-i];
        for (int n = 0; n + 8 < 59; n++)
            s[n+8] = s[n] ^ s[n+1] ^ s[n+4] ^ s[n+5] ^ s[n+6] ^ s[n+7];
        cw[0] = w[8];
        for (int k = 1; k < 52; k++) cw[k] = w[8] ^ s[k-1];
        return cw;
    endfunction

    task automatic encode_word(input logic [8:0] w, input bit stalls);
        logic [51:0] exp;
        logic        held;
        exp = codeword(w);
        check(in_ready == 1'b1 && out_valid == 1'b0, "R7", int'(in_ready), 1);
        in_valid = 1'b1;
        in_word  = w;
        @(posedge clk);
        @(negedge clk);
        // R2: conflicting word offered during the whole emission
        in_word = ~w;
        for (int k = 0; k < 52; k++) begin
            if (stalls && (((int'(w) * 7 + k) % 5) == 0)) begin
                out_ready = 1'b0;
                held = out_sym;
                @(posedge clk);
                @(negedge clk);
                check(out_valid == 1'b1 && out_sym == held && out_last == (k == 51),
                      "R6", int'(out_sym), int'(held));
            end
            out_ready = 1'b1;
            check(in_ready == 1'b0, "R2", int'(in_ready), 0);
            check(out_valid == 1'b1, (k == 0) ? "R3" : "R4", int'(out_valid), 1);
            check(out_sym == exp[k], (k == 0) ? "R3" : "R4", int'(out_sym), int'(exp[k]));
            check(out_last == (k == 51), "R5", int'(out_last), int'(k == 51));
            @(posedge clk);
            @(negedge clk);
        end
        in_valid  = 1'b0;
        out_ready = 1'b0;
        check(out_valid == 1'b0 && in_ready == 1'b1, "R7", int'(out_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && in_ready == 1'b1, "R1", int'(out_valid), 0);
        for (int w = 0; w < 512; w++) encode_word(9'(w), 1'b0);
        for (int w = 0; w < 512; w++) encode_word(9'(w), 1'b1);
        // R5: nothing more appears once a codeword ends
        repeat (4) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R5", int'(out_valid), 0);
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule